// File: doc/BRIEF.md
# Operand Bypass and Load Hazard Control

This block is the hazard control for a five-stage integer pipeline (fetch, decode, execute, memory, write-back). Every cycle it takes the two source register numbers of the instruction sitting in execute and compares them with the destination registers held further down the pipeline. For each ALU input it picks one of three operand sources: the register file, the result waiting in the execute/memory register, or the result waiting in the memory/write-back register. Because of this, an ALU result reaches the very next instruction without a stall.

The block also watches for a load in execute whose destination is read by the instruction now in decode. In that case the loaded value cannot arrive in time even with bypassing. It raises a stall that holds the program counter and the fetch/decode register for one cycle. In the same cycle it raises a bubble request that zeroes the control fields entering execute. The register file writes early in the cycle and reads late, so a write-back to decode overlap needs no path of its own.

All outputs are combinational in the current inputs. The clock and reset serve only the built-in checks.

Top module: `fwd_hazard_ctrl`

## Requirements
- R1: With every write enable low and no load in execute, both operand selects are 2'b00 (register file), and stall and bubble are low.
- R2: When the execute/memory stage writes a nonzero register equal to an execute source, that operand's select is 2'b10.
- R3: When only the memory/write-back stage writes a nonzero register equal to an execute source, that operand's select is 2'b01.
- R4: When both later stages write the same register as an execute source, the execute/memory result wins and the select is 2'b10.
- R5: Register 0 is never bypassed and never causes a stall, whatever the write enables and load flag are.
- R6: A destination match whose write enable is low changes neither a select nor the stall.
- R7: A load in execute with write enable high and a nonzero destination equal to either decode source raises stall and bubble together in that cycle.
- R8: An instruction in execute that is not a load never causes a stall or bubble.
- R9: The two operand selects are computed independently: each one depends only on its own source register number.
- R10: Select value 2'b11 never appears on either operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used by the checks only |
| rst_ni | input | 1 | Active-low asynchronous reset, used by the checks only |
| id_src_a_i | input | 5 | First source register of the decode instruction |
| id_src_b_i | input | 5 | Second source register of the decode instruction |
| ex_src_a_i | input | 5 | First source register of the execute instruction |
| ex_src_b_i | input | 5 | Second source register of the execute instruction |
| ex_dst_i | input | 5 | Destination register of the execute instruction |
| ex_wen_i | input | 1 | Execute instruction writes its destination |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_dst_i | input | 5 | Destination held in the execute/memory register |
| mem_wen_i | input | 1 | Write enable held in the execute/memory register |
| wb_dst_i | input | 5 | Destination held in the memory/write-back register |
| wb_wen_i | input | 1 | Write enable held in the memory/write-back register |
| fwd_a_o | output | 2 | First ALU operand source: 00 file, 10 exec/mem, 01 mem/wb |
| fwd_b_o | output | 2 | Second ALU operand source, same encoding |
| stall_o | output | 1 | Hold program counter and fetch/decode register |
| bubble_o | output | 1 | Zero control fields entering execute |

## Verification
The hardest case to reach is the one where both later stages write the same register as an execute source. The same pattern is that register 0 is the only match, with write enables and the load flag set. Uniform random register numbers almost never collide. The stimulus therefore draws every register number from a pool of four values that includes 0, and sets write enables and the load flag about half the time. Directed vectors also pin each collision down exactly.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF = 2'b00,
    SEL_MW = 2'b01,
    SEL_EM = 2'b10
  } opnd_sel_e;
endpackage

// File: rtl/fwd_sel_unit.sv
module fwd_sel_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] src_i,
  input  logic [REG_W-1:0] mem_dst_i,
  input  logic             mem_wen_i,
  input  logic [REG_W-1:0] wb_dst_i,
  input  logic             wb_wen_i,
  output opnd_sel_e        sel_o
);
  logic src_live;
  logic hit_mem, hit_wb;

  assign src_live = (src_i != '0);
  assign hit_mem  = src_live && mem_wen_i && (mem_dst_i == src_i);
  assign hit_wb   = src_live && wb_wen_i && (wb_dst_i == src_i);

  // younger result wins
  always_comb begin
    if (hit_mem)     sel_o = SEL_EM;
    else if (hit_wb) sel_o = SEL_MW;
    else             sel_o = SEL_RF;
  end

  a_r5_zero_src_no_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (sel_o == SEL_RF));
  a_r10_no_illegal_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  a_r6_no_wen_no_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_wen_i && !wb_wen_i) |-> (sel_o == SEL_RF));
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SRC-1:0][REG_W-1:0] id_src_i,
  input  logic [REG_W-1:0]              ex_dst_i,
  input  logic                          ex_wen_i,
  input  logic                          ex_load_i,
  output logic                          hazard_o
);
  logic [NUM_SRC-1:0] match;
  logic               load_live;

  assign load_live = ex_load_i && ex_wen_i && (ex_dst_i != '0);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign match[g] = (id_src_i[g] == ex_dst_i);
  end

  assign hazard_o = load_live && (|match);

  a_r8_non_load_no_hazard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_load_i |-> !hazard_o);
  a_r5_zero_dst_no_hazard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_dst_i == '0) |-> !hazard_o);
endmodule

// File: rtl/fwd_hazard_ctrl.sv
module fwd_hazard_ctrl
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] id_src_a_i,
  input  logic [REG_W-1:0] id_src_b_i,
  input  logic [REG_W-1:0] ex_src_a_i,
  input  logic [REG_W-1:0] ex_src_b_i,
  input  logic [REG_W-1:0] ex_dst_i,
  input  logic             ex_wen_i,
  input  logic             ex_load_i,
  input  logic [REG_W-1:0] mem_dst_i,
  input  logic             mem_wen_i,
  input  logic [REG_W-1:0] wb_dst_i,
  input  logic             wb_wen_i,
  output logic [1:0]       fwd_a_o,
  output logic [1:0]       fwd_b_o,
  output logic             stall_o,
  output logic             bubble_o
);
  localparam int unsigned NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0] ex_src;
  logic [NUM_SRC-1:0][REG_W-1:0] id_src;
  opnd_sel_e [NUM_SRC-1:0]       sel;
  logic                          hazard;

  assign ex_src = {ex_src_b_i, ex_src_a_i};
  assign id_src = {id_src_b_i, id_src_a_i};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
    fwd_sel_unit #(.REG_W(REG_W)) u_sel (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (ex_src[g]),
      .mem_dst_i (mem_dst_i),
      .mem_wen_i (mem_wen_i),
      .wb_dst_i  (wb_dst_i),
      .wb_wen_i  (wb_wen_i),
      .sel_o     (sel[g])
    );
  end

  load_use_detect #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_lud (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .id_src_i  (id_src),
    .ex_dst_i  (ex_dst_i),
    .ex_wen_i  (ex_wen_i),
    .ex_load_i (ex_load_i),
    .hazard_o  (hazard)
  );

  assign fwd_a_o  = sel[0];
  assign fwd_b_o  = sel[1];
  assign stall_o  = hazard;
  assign bubble_o = hazard;

  a_r7_stall_with_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o == bubble_o);
  a_r4_mem_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wen_i && ex_src_a_i != '0 && mem_dst_i == ex_src_a_i) |-> (fwd_a_o == 2'b10));
endmodule

// File: tb/fwd_hazard_ctrl_tb.sv
module fwd_hazard_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] id_src_a_i, id_src_b_i, ex_src_a_i, ex_src_b_i, ex_dst_i, mem_dst_i, wb_dst_i;
  logic       ex_wen_i, ex_load_i, mem_wen_i, wb_wen_i;
  logic [1:0] fwd_a_o, fwd_b_o;
  logic       stall_o, bubble_o;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #5 clk_i = ~clk_i;

  fwd_hazard_ctrl u_dut (.*);

  function automatic logic [1:0] exp_sel(input logic [4:0] s, input logic [4:0] md,
                                         input logic mw, input logic [4:0] wd, input logic ww);
    if (s == 5'd0) return 2'b00;
    if (mw && md == s) return 2'b10;
    if (ww && wd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic exp_stall();
    if (!ex_load_i || !ex_wen_i || ex_dst_i == 5'd0) return 1'b0;
    return (id_src_a_i == ex_dst_i) || (id_src_b_i == ex_dst_i);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, {6'd0, fwd_a_o}, {6'd0, exp_sel(ex_src_a_i, mem_dst_i, mem_wen_i, wb_dst_i, wb_wen_i)});
    chk(req, {6'd0, fwd_b_o}, {6'd0, exp_sel(ex_src_b_i, mem_dst_i, mem_wen_i, wb_dst_i, wb_wen_i)});
    chk(req, {7'd0, stall_o}, {7'd0, exp_stall()});
    chk(req, {7'd0, bubble_o}, {7'd0, exp_stall()});
  endtask

  task automatic drive(input logic [4:0] ia, ib, ea, eb, ed, input logic ew, el,
                       input logic [4:0] md, input logic mw, input logic [4:0] wd, input logic ww);
    @(negedge clk_i);
    id_src_a_i = ia; id_src_b_i = ib; ex_src_a_i = ea; ex_src_b_i = eb;
    ex_dst_i = ed; ex_wen_i = ew; ex_load_i = el;
    mem_dst_i = md; mem_wen_i = mw; wb_dst_i = wd; wb_wen_i = ww;
    #1;
  endtask

  function automatic logic [4:0] pick();
    logic [1:0] k = 2'($urandom_range(3));
    case (k)
      2'd0: return 5'd0;
      2'd1: return 5'd3;
      2'd2: return 5'd7;
      default: return 5'd31;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    drive(5'd4, 5'd5, 5'd4, 5'd5, 5'd4, 1'b0, 1'b0, 5'd4, 1'b0, 5'd5, 1'b0);
    // R1 reset / idle
    chk("R1", {6'd0, fwd_a_o}, 8'h00);
    chk("R1", {6'd0, fwd_b_o}, 8'h00);
    chk("R1", {7'd0, stall_o}, 8'h00);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    drive(5'd1, 5'd2, 5'd6, 5'd9, 5'd8, 1'b1, 1'b0, 5'd6, 1'b1, 5'd2, 1'b1);
    chk("R2", {6'd0, fwd_a_o}, 8'h02);
    chk("R9", {6'd0, fwd_b_o}, 8'h00);
    drive(5'd1, 5'd2, 5'd6, 5'd9, 5'd8, 1'b1, 1'b0, 5'd3, 1'b1, 5'd9, 1'b1);
    chk("R3", {6'd0, fwd_b_o}, 8'h01);
    chk("R9", {6'd0, fwd_a_o}, 8'h00);
    drive(5'd1, 5'd2, 5'd12, 5'd12, 5'd8, 1'b1, 1'b0, 5'd12, 1'b1, 5'd12, 1'b1);
    chk("R4", {6'd0, fwd_a_o}, 8'h02);
    chk("R4", {6'd0, fwd_b_o}, 8'h02);
    drive(5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1);
    chk("R5", {6'd0, fwd_a_o}, 8'h00);
    chk("R5", {6'd0, fwd_b_o}, 8'h00);
    chk("R5", {7'd0, stall_o}, 8'h00);
    drive(5'd10, 5'd2, 5'd10, 5'd10, 5'd10, 1'b0, 1'b1, 5'd10, 1'b0, 5'd10, 1'b0);
    chk("R6", {6'd0, fwd_a_o}, 8'h00);
    chk("R6", {7'd0, stall_o}, 8'h00);
    drive(5'd1, 5'd14, 5'd3, 5'd4, 5'd14, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    chk("R7", {7'd0, stall_o}, 8'h01);
    chk("R7", {7'd0, bubble_o}, 8'h01);
    drive(5'd14, 5'd1, 5'd3, 5'd4, 5'd14, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0);
    chk("R7", {7'd0, stall_o}, 8'h01);
    drive(5'd14, 5'd14, 5'd3, 5'd4, 5'd14, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0);
    chk("R8", {7'd0, stall_o}, 8'h00);
    chk("R8", {7'd0, bubble_o}, 8'h00);

    for (int i = 0; i < 2000; i++) begin
      drive(pick(), pick(), pick(), pick(), pick(), 1'($urandom_range(1)), 1'($urandom_range(1)),
            pick(), 1'($urandom_range(1)), pick(), 1'($urandom_range(1)));
      check_all("R2 R3 R4 R5 R6 R7 R8 R10");
      if (fwd_a_o == 2'b11 || fwd_b_o == 2'b11) chk("R10", 8'h03, 8'h00);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule